// File: doc/BRIEF.md
# SHA-1 Block Compression Engine

This engine compresses a message that has already been padded into 512-bit blocks. On a start pulse it takes a block count and loads the standard five-word initial chaining value. For each block it reads sixteen 32-bit words from an external word-addressed memory that returns data one cycle after the read. It then runs the eighty SHA-1 rounds and folds the result into the chaining value. When the last block has been folded, it raises done for one cycle. The 160-bit digest then stays frozen until the next run finishes.

Round words are not expanded in a separate phase. The first sixteen come straight from the memory read port while the rounds that use them execute. The remaining sixty-four come from a sixteen-entry sliding window, one word per round.

A block costs 81 cycles: eighty round cycles plus one cycle that folds the result and fetches the first word of the next block. A run of N blocks finishes 1 + 81·N cycles after start is sampled. Block b, word j sits at memory address 16·b + j.

Top module: `sha1_core`

## Requirements
- R1: While reset is held and after it is released, done and mem_rd are 0 and digest equals 67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0, with word a in bits 159:128 and word e in bits 31:0.
- R2: A run of N blocks issues exactly 16·N reads, at addresses 0, 1, 2, … 16·N−1 in that order. Each read whose previous cycle was also a read targets the next address. No read is issued in the cycle done is high.
- R3: For one-block messages the digest equals the SHA-1 value of the block, which uses the choose, parity, majority and parity functions in rounds 0–19, 20–39, 40–59 and 60–79. The word returned one cycle after a read serves as w[j] for j < 16.
- R4: Multi-block messages chain each block's result, as a word-wise sum modulo 2^32, into the next block's starting state. The final digest matches the SHA-1 value of the whole message.
- R5: For N ≥ 1 blocks, done rises 1 + 81·N cycles after the clock edge at which start was sampled.
- R6: Done is high for exactly one cycle per run.
- R7: Digest changes only in a cycle where done is high. It holds after done until a later run completes.
- R8: A start pulse while a run is in progress is ignored. Neither the result nor the finish time of that run changes.
- R9: Start with a block count of 0 raises done in the next cycle, with the digest equal to the initial value of R1.
- R10: A new run started right after done begins again from the initial chaining value. It gives the same digest as an isolated run of the same message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only when idle |
| num_blocks | input | BLK_W | Number of 512-bit blocks in the message |
| mem_rd | output | 1 | Read request to the message memory |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| digest | output | 160 | Final hash, word a in the top 32 bits |

## Verification
Two actions fall in the same cycle: the fold of block j into the chaining value, and the fetch of word 0 of block j+1. The same cycle also has to load the working registers with the freshly folded sum. Two-block and three-block messages force this overlap. The engine is judged by the digest against published SHA-1 values and an in-bench reference model, by a finish time of exactly 1 + 81·N cycles, and by a gap-free ascending read-address trace across each block boundary.

// File: rtl/sha1_pkg.sv
package sha1_pkg;

   localparam int WORD_W   = 32;
   localparam int N_ROUNDS = 80;
   localparam int WIN_LEN  = 16;
   localparam int RND_W    = $clog2(N_ROUNDS);
   localparam int IDX_W    = $clog2(WIN_LEN);

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      word_t a;
      word_t b;
      word_t c;
      word_t d;
      word_t e;
   } hstate_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_PRIME,
      PH_ROUND,
      PH_FOLD
   } phase_e;

   localparam hstate_t SHA1_IV = '{
      a: 32'h67452301,
      b: 32'hEFCDAB89,
      c: 32'h98BADCFE,
      d: 32'h10325476,
      e: 32'hC3D2E1F0
   };

   function automatic word_t rotl(input word_t x, input int unsigned n);
      return (x << n) | (x >> (WORD_W - n));
   endfunction

   function automatic hstate_t add_state(input hstate_t p, input hstate_t q);
      hstate_t r;
      r.a = p.a + q.a;
      r.b = p.b + q.b;
      r.c = p.c + q.c;
      r.d = p.d + q.d;
      r.e = p.e + q.e;
      return r;
   endfunction

endpackage

// File: rtl/sha1_msg_sched.sv
module sha1_msg_sched
   import sha1_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  shift_en,
   input  logic  from_mem,
   input  word_t mem_word,
   output word_t w_cur
);

   word_t win [WIN_LEN];

   // win[WIN_LEN-1] holds w[i-1]; win[0] holds w[i-16]
   word_t expanded;
   assign expanded = rotl(win[WIN_LEN-3] ^ win[WIN_LEN-8] ^ win[WIN_LEN-14] ^ win[0], 1);
   assign w_cur    = from_mem ? mem_word : expanded;

   genvar gi;
   generate
      for (gi = 0; gi < WIN_LEN; gi++) begin : g_win
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               win[gi] <= '0;
            else if (shift_en) begin
               if (gi == WIN_LEN - 1)
                  win[gi] <= w_cur;
               else
                  win[gi] <= win[(gi + 1) % WIN_LEN];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sha1_round.sv
module sha1_round
   import sha1_pkg::*;
(
   input  hstate_t    cur,
   input  word_t      w,
   input  logic [1:0] stage,
   output hstate_t    nxt
);

   word_t f_val;
   word_t k_val;

   always_comb begin
      unique case (stage)
         2'd0: begin
            f_val = (cur.b & cur.c) | (~cur.b & cur.d);
            k_val = 32'h5A827999;
         end
         2'd1: begin
            f_val = cur.b ^ cur.c ^ cur.d;
            k_val = 32'h6ED9EBA1;
         end
         2'd2: begin
            f_val = (cur.b & cur.c) | (cur.b & cur.d) | (cur.c & cur.d);
            k_val = 32'h8F1BBCDC;
         end
         default: begin
            f_val = cur.b ^ cur.c ^ cur.d;
            k_val = 32'hCA62C1D6;
         end
      endcase
   end

   always_comb begin
      nxt.a = rotl(cur.a, 5) + f_val + cur.e + k_val + w;
      nxt.b = cur.a;
      nxt.c = rotl(cur.b, 30);
      nxt.d = cur.c;
      nxt.e = cur.d;
   end

endmodule

// File: rtl/sha1_ctrl.sv
module sha1_ctrl
   import sha1_pkg::*;
#(
   parameter int BLK_W  = 8,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BLK_W-1:0]  num_blocks,
   output logic              busy,
   output logic              init_run,
   output logic              zero_run,
   output logic              round_en,
   output logic              fold,
   output logic              last_blk,
   output logic [RND_W-1:0]  rnd,
   output logic [1:0]        stage,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              done
);

   phase_e           phase;
   logic [BLK_W-1:0] blk;
   logic [BLK_W-1:0] nblk;

   assign busy     = (phase != PH_IDLE);
   assign init_run = (phase == PH_IDLE) && start && (num_blocks != '0);
   assign zero_run = (phase == PH_IDLE) && start && (num_blocks == '0);
   assign round_en = (phase == PH_ROUND);
   assign fold     = (phase == PH_FOLD);
   assign last_blk = (blk == nblk - BLK_W'(1));

   always_comb begin
      if (rnd < RND_W'(20))      stage = 2'd0;
      else if (rnd < RND_W'(40)) stage = 2'd1;
      else if (rnd < RND_W'(60)) stage = 2'd2;
      else                       stage = 2'd3;
   end

   // read issue: priming cycle, rounds 0..14 (words 1..15), fold of a non-final block
   logic [BLK_W-1:0] blk_sel;
   logic [IDX_W-1:0] idx;

   always_comb begin
      mem_rd  = 1'b0;
      blk_sel = blk;
      idx     = '0;
      unique case (phase)
         PH_PRIME: mem_rd = 1'b1;
         PH_ROUND: begin
            mem_rd = (rnd < RND_W'(WIN_LEN - 1));
            idx    = IDX_W'(rnd + RND_W'(1));
         end
         PH_FOLD: begin
            mem_rd  = !last_blk;
            blk_sel = blk + BLK_W'(1);
         end
         default: ;
      endcase
   end

   assign mem_addr = ADDR_W'({blk_sel, idx});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         rnd   <= '0;
         blk   <= '0;
         nblk  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (zero_run)
                  done <= 1'b1;
               else if (init_run) begin
                  nblk  <= num_blocks;
                  blk   <= '0;
                  phase <= PH_PRIME;
               end
            end
            PH_PRIME: begin
               rnd   <= '0;
               phase <= PH_ROUND;
            end
            PH_ROUND: begin
               rnd <= rnd + RND_W'(1);
               if (rnd == RND_W'(N_ROUNDS - 1))
                  phase <= PH_FOLD;
            end
            default: begin
               rnd <= '0;
               if (last_blk) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  blk   <= blk + BLK_W'(1);
                  phase <= PH_ROUND;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/sha1_core.sv
module sha1_core
   import sha1_pkg::*;
#(
   parameter int BLK_W  = 8,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BLK_W-1:0]  num_blocks,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [31:0]       mem_rdata,
   output logic              done,
   output logic [159:0]      digest
);

   generate
      if (BLK_W < 1) begin : g_bad_blk
         $error("sha1_core: BLK_W must be at least 1");
      end
      if (ADDR_W < BLK_W + IDX_W) begin : g_bad_addr
         $error("sha1_core: ADDR_W too narrow for BLK_W blocks of 16 words");
      end
   endgenerate

   logic             busy;
   logic             init_run;
   logic             zero_run;
   logic             round_en;
   logic             fold;
   logic             last_blk;
   logic [RND_W-1:0] rnd;
   logic [1:0]       stage;
   word_t            w_cur;
   hstate_t          chain;
   hstate_t          work;
   hstate_t          work_nxt;
   hstate_t          folded;
   logic [159:0]     dig_q;

   sha1_ctrl #(.BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .num_blocks (num_blocks),
      .busy       (busy),
      .init_run   (init_run),
      .zero_run   (zero_run),
      .round_en   (round_en),
      .fold       (fold),
      .last_blk   (last_blk),
      .rnd        (rnd),
      .stage      (stage),
      .mem_rd     (mem_rd),
      .mem_addr   (mem_addr),
      .done       (done)
   );

   sha1_msg_sched u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (round_en),
      .from_mem (rnd < RND_W'(WIN_LEN)),
      .mem_word (mem_rdata),
      .w_cur    (w_cur)
   );

   sha1_round u_round (
      .cur   (work),
      .w     (w_cur),
      .stage (stage),
      .nxt   (work_nxt)
   );

   assign folded = add_state(chain, work);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= SHA1_IV;
         work  <= SHA1_IV;
         dig_q <= SHA1_IV;
      end else begin
         if (init_run) begin
            chain <= SHA1_IV;
            work  <= SHA1_IV;
         end
         if (zero_run)
            dig_q <= SHA1_IV;
         if (round_en)
            work <= work_nxt;
         if (fold) begin
            chain <= folded;
            work  <= folded;
            if (last_blk)
               dig_q <= folded;
         end
      end
   end

   assign digest = dig_q;

endmodule

// File: rtl/sha1_core_chk.sv
module sha1_core_chk #(
   parameter int BLK_W  = 8,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [BLK_W-1:0]  num_blocks,
   input logic              busy,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done,
   input logic [159:0]      digest
);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                        // R6

   AST_ADDR_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R2

   AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_rd);                                                      // R2

   AST_DIGEST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(digest));                                             // R7

   AST_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && num_blocks == '0) |=> done);                         // R9

   AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !mem_rd);                                         // R2

endmodule

bind sha1_core sha1_core_chk #(.BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .num_blocks (num_blocks),
   .busy       (busy),
   .mem_rd     (mem_rd),
   .mem_addr   (mem_addr),
   .done       (done),
   .digest     (digest)
);

// File: tb/tb_sha1_core.sv
module tb_sha1_core;

   localparam int BLK_W  = 8;
   localparam int ADDR_W = 12;
   localparam logic [159:0] IV = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [BLK_W-1:0]  num_blocks = '0;
   logic              mem_rd;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0]       mem_rdata;
   logic              done;
   logic [159:0]      digest;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   sha1_core #(.BLK_W(BLK_W), .ADDR_W(ADDR_W)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .num_blocks (num_blocks),
      .mem_rd     (mem_rd),
      .mem_addr   (mem_addr),
      .mem_rdata  (mem_rdata),
      .done       (done),
      .digest     (digest)
   );

   // message memory, one-cycle read latency
   logic [31:0] mem [64];
   always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];

   // read-address monitor
   int rd_cnt  = 0;
   int rd_err  = 0;
   always @(negedge clk) begin
      if (rst_n && mem_rd) begin
         if (int'(mem_addr) != rd_cnt) rd_err++;
         rd_cnt++;
      end
   end

   task automatic chk(input logic ok, input string req, input logic [159:0] act, input logic [159:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rl(input logic [31:0] x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   // independent reference model over the memory contents
   function automatic logic [159:0] ref_sha(input int n);
      logic [31:0] h [5];
      logic [31:0] w [80];
      logic [31:0] a, b, c, d, e, f, k, t;
      h[0] = IV[159:128]; h[1] = IV[127:96]; h[2] = IV[95:64];
      h[3] = IV[63:32];   h[4] = IV[31:0];
      for (int bk = 0; bk < n; bk++) begin
         for (int i = 0; i < 80; i++)
            w[i] = (i < 16) ? mem[bk*16 + i]
                            : rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
         a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4];
         for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            t = rl(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rl(b, 30); b = a; a = t;
         end
         h[0] += a; h[1] += b; h[2] += c; h[3] += d; h[4] += e;
      end
      return {h[0], h[1], h[2], h[3], h[4]};
   endfunction

   task automatic load_msg(input int kind);
      logic [31:0] lfsr = 32'hACE1_2468;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      case (kind)
         0: mem[0] = 32'h80000000;                               // empty message
         1: begin mem[0] = 32'h61626380; mem[15] = 32'h18; end   // "abc"
         2: begin                                                // 56-byte alphabet string
            for (int j = 0; j < 14; j++)
               mem[j] = {8'(97 + j), 8'(98 + j), 8'(99 + j), 8'(100 + j)};
            mem[14] = 32'h80000000;
            mem[31] = 32'h1C0;
         end
         default: begin
            for (int i = 0; i < 48; i++) begin
               lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
               mem[i] = lfsr ^ (32'h9E3779B9 * i);
            end
         end
      endcase
   endtask

   // run one message; returns cycles from start edge to done
   task automatic run(input int n, input logic inject, output int lat);
      int cyc = 0;
      rd_cnt = 0;
      rd_err = 0;
      @(negedge clk);
      start = 1'b1;
      num_blocks = BLK_W'(n);
      lat = -1;
      for (int guard = 0; guard < 2000; guard++) begin
         @(negedge clk);
         cyc++;
         start = 1'b0;
         if (inject && cyc == 40) begin start = 1'b1; num_blocks = BLK_W'(1); end
         if (inject && cyc == 41) begin start = 1'b0; num_blocks = BLK_W'(n); end
         if (done) begin lat = cyc - 1; break; end
      end
      start = 1'b0;
      if (lat < 0) chk(1'b0, "R5 watchdog", 160'(cyc), 160'(1 + 81*n));
   endtask

   typedef struct packed {
      logic [1:0]   kind;
      logic [7:0]   nblk;
      logic         use_model;
      logic         inject;
      logic [159:0] exp;
   } vec_t;

   localparam vec_t [0:4] VEC = '{
      '{kind: 2'd1, nblk: 8'd1, use_model: 1'b0, inject: 1'b0,
        exp: 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D},
      '{kind: 2'd0, nblk: 8'd1, use_model: 1'b0, inject: 1'b0,
        exp: 160'hDA39A3EE_5E6B4B0D_3255BFEF_95601890_AFD80709},
      '{kind: 2'd2, nblk: 8'd2, use_model: 1'b0, inject: 1'b1,
        exp: 160'h84983E44_1C3BD26E_BAAE4AA1_F95129E5_E54670F1},
      '{kind: 2'd3, nblk: 8'd3, use_model: 1'b1, inject: 1'b0, exp: 160'h0},
      '{kind: 2'd1, nblk: 8'd1, use_model: 1'b0, inject: 1'b0,
        exp: 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D}
   };

   initial begin
      #(20 * 150000);
      chk(1'b0, "R5 global watchdog", 160'd0, 160'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lat;
      logic [159:0] exp, held;
      repeat (3) @(negedge clk);
      chk(done == 1'b0 && mem_rd == 1'b0, "R1 outputs in reset", {158'd0, done, mem_rd}, 160'd0);
      chk(digest == IV, "R1 digest in reset", digest, IV);
      rst_n = 1'b1;
      @(negedge clk);
      chk(digest == IV && !done && !mem_rd, "R1 after release", digest, IV);

      for (int v = 0; v < 5; v++) begin
         load_msg(int'(VEC[v].kind));
         exp = VEC[v].use_model ? ref_sha(int'(VEC[v].nblk)) : VEC[v].exp;
         run(int'(VEC[v].nblk), VEC[v].inject, lat);
         if (VEC[v].nblk == 8'd1)
            chk(digest == exp, "R3 single-block digest", digest, exp);
         else
            chk(digest == exp, "R4 chained digest", digest, exp);
         if (v == 4) chk(digest == exp, "R10 rerun from initial value", digest, exp);
         if (VEC[v].inject) chk(digest == exp, "R8 start while busy ignored", digest, exp);
         chk(lat == 1 + 81 * int'(VEC[v].nblk), "R5 latency", 160'(lat), 160'(1 + 81 * int'(VEC[v].nblk)));
         chk(rd_cnt == 16 * int'(VEC[v].nblk) && rd_err == 0, "R2 read trace",
             160'(rd_cnt), 160'(16 * int'(VEC[v].nblk)));
         @(negedge clk);
         chk(!done, "R6 done single cycle", 160'(done), 160'd0);
      end

      // R7: hold for several idle cycles
      held = digest;
      repeat (6) @(negedge clk);
      chk(digest == held, "R7 digest held while idle", digest, held);

      // R7: digest does not move during a later run until its done
      load_msg(2);
      @(negedge clk);
      start = 1'b1; num_blocks = 8'd2;
      @(negedge clk);
      start = 1'b0;
      repeat (100) @(negedge clk);
      chk(digest == held, "R7 digest held mid-run", digest, held);
      while (!done) @(negedge clk);
      chk(digest == 160'h84983E44_1C3BD26E_BAAE4AA1_F95129E5_E54670F1, "R4 second two-block run",
          digest, 160'h84983E44_1C3BD26E_BAAE4AA1_F95129E5_E54670F1);

      // R9: zero blocks
      run(0, 1'b0, lat);
      chk(lat == 0, "R9 zero-block done timing", 160'(lat), 160'd0);
      chk(digest == IV, "R9 zero-block digest", digest, IV);
      chk(rd_cnt == 0, "R9 zero-block no reads", 160'(rd_cnt), 160'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule